// File: doc/BRIEF.md
# Write-Through Byte Cache with Fill-on-Miss

This block is a small, fully associative data cache. It sits between a processor load/store port and a slower byte-wide memory. The processor issues one access at a time with a one-cycle read or write strobe. The cache answers with a one-cycle ready pulse and, for loads, the byte that was read. Every store is written through to memory as a single byte. A store that misses first pulls its whole block into a line, the same way a load miss does. Evicting a line never causes a memory write, because memory always already holds every stored byte.

The default build uses 5-bit byte addresses and 2-byte blocks, so bit 0 selects the byte and bits 4:1 form the tag. It holds two lines. When every line is valid, a miss replaces the least recently used line. Free-running hit and miss counters record the outcome of each processor access. Memory reads always return a whole block, and memory writes always carry one byte. Both use a request/acknowledge handshake.

Top module: `wtc_cache`

## Requirements
- R1: After synchronous reset, cpu_ready, mem_rd_req and mem_wr_req are low, both counters read zero and every line is invalid, so the first access to any address misses.
- R2: An address splits into a byte offset (bit 0) and a tag (bits 4:1). An access hits when a valid line holds its tag, so both bytes of a block share a line.
- R3: A load hit returns the cached byte with no memory transaction, and cpu_ready rises on the third rising edge counted from the edge that accepts the strobe.
- R4: A load miss issues exactly one block read whose address has offset bits zero. The block returns on mem_rdata with byte 0 in bits 7:0. The requested byte is returned, and the line is filled with the whole block.
- R5: Every store, hit or miss, causes exactly one memory write carrying the full byte address and the store byte, and later loads of that address return the new byte.
- R6: On a store miss the block read completes before the byte write is issued, and the store byte is merged into the filled line.
- R7: Replacing a valid line causes no memory write, so a load miss that evicts produces only the block read.
- R8: With all lines valid, a miss replaces the least recently used line, and both hits and fills count as a use.
- R9: Each accepted access adds exactly one to either hit_count (a valid line with a matching tag was found) or miss_count.
- R10: cpu_ready is a one-cycle pulse. It is given only after every memory transaction of the access has been acknowledged, and it is never given while a memory request is pending.
- R11: A strobe that arrives while an access is in progress is ignored. It causes no count, no memory transaction and no change to memory.
- R12: mem_rd_req and mem_wr_req are never high together. Each is held, with a stable address (and data for writes), until the cycle in which mem_ack is seen, and then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Load strobe, one cycle |
| cpu_wr | input | 1 | Store strobe, one cycle |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | DATA_W | Store byte |
| cpu_rdata | output | DATA_W | Load result, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_rd_req | output | 1 | Block read request |
| mem_wr_req | output | 1 | Byte write request |
| mem_addr | output | ADDR_W | Memory address (block-aligned for reads) |
| mem_wdata | output | DATA_W | Byte to write |
| mem_rdata | input | BLOCK_BYTES*DATA_W | Block returned with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
A load hit is due on the third rising edge after the strobe is accepted, and the bench counts edges to require exactly that. Every other result depends on memory latency. For those, the bench waits for the ready pulse and then compares the transactions logged by its memory model: read and write counts, addresses, data and the order of acknowledgements. The counters, read data and the absence of a memory request are all sampled on the falling edge where ready is first seen high. The next falling edge confirms that the pulse has ended. A reference model of tags, valid bits and the LRU pointer predicts every hit and miss, including the eviction victims.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_RESP  = 3'd2,
    ST_FILL  = 3'd3,
    ST_STORE = 3'd4
  } wtc_state_t;

endpackage

// File: rtl/wtc_tags.sv
module wtc_tags #(
  parameter int LINES = 2,
  parameter int TAG_W = 4,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             alloc_en,
  input  logic [WAY_W-1:0] alloc_way,
  input  logic [TAG_W-1:0] alloc_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic             free_any,
  output logic [WAY_W-1:0] free_way
);

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      assign match[g] = valid_q[g] && (tag_q[g] == look_tag);

      always_ff @(posedge clk) begin
        if (rst) begin
          valid_q[g] <= 1'b0;
          tag_q[g]   <= '0;
        end else if (alloc_en && (alloc_way == WAY_W'(g))) begin
          valid_q[g] <= 1'b1;
          tag_q[g]   <= alloc_tag;
        end
      end

      for (genvar h = g + 1; h < LINES; h++) begin : g_pair
        // R2: one tag never lives in two lines
        a_r2_unique_tag: assert property (@(posedge clk) disable iff (rst)
          !(valid_q[g] && valid_q[h] && (tag_q[g] == tag_q[h])));
      end
    end
  endgenerate

  always_comb begin
    hit      = |match;
    hit_way  = '0;
    free_any = ~&valid_q;
    free_way = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i])    hit_way  = WAY_W'(i);
      if (!valid_q[i]) free_way = WAY_W'(i);
    end
  end

  // R2: a lookup matches at most one line
  a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

endmodule

// File: rtl/wtc_lru.sv
module wtc_lru #(
  parameter int LINES = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] oldest_way
);

  logic [WAY_W-1:0] age_q [LINES];
  logic [LINES-1:0] is_oldest;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_age
      assign is_oldest[g] = (age_q[g] == WAY_W'(LINES - 1));

      always_ff @(posedge clk) begin
        if (rst) begin
          age_q[g] <= WAY_W'(LINES - 1 - g);
        end else if (touch_en) begin
          if (touch_way == WAY_W'(g))
            age_q[g] <= '0;
          else if (age_q[g] < age_q[touch_way])
            age_q[g] <= age_q[g] + 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    oldest_way = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (is_oldest[i]) oldest_way = WAY_W'(i);
  end

  // R8: the ages stay a permutation, so exactly one line is the oldest
  a_r8_one_oldest: assert property (@(posedge clk) disable iff (rst)
    $countones(is_oldest) == 1);

  // R8: a touched line is never the replacement choice next cycle
  a_r8_touched_young: assert property (@(posedge clk) disable iff (rst)
    (touch_en && LINES > 1) |=> (oldest_way != $past(touch_way)));

endmodule

// File: rtl/wtc_data.sv
module wtc_data #(
  parameter int LINES       = 2,
  parameter int BLOCK_BYTES = 2,
  parameter int DATA_W      = 8,
  parameter int WAY_W       = 1
) (
  input  logic                          clk,
  input  logic [WAY_W-1:0]              wr_way,
  input  logic [BLOCK_BYTES-1:0]        wr_lane_en,
  input  logic [BLOCK_BYTES*DATA_W-1:0] wr_data,
  input  logic [WAY_W-1:0]              rd_way,
  output logic [BLOCK_BYTES*DATA_W-1:0] rd_data
);

  genvar g;
  generate
    for (g = 0; g < BLOCK_BYTES; g++) begin : g_lane
      logic [DATA_W-1:0] ram [LINES];
      logic [DATA_W-1:0] rd_q;

      always_ff @(posedge clk) begin
        if (wr_lane_en[g])
          ram[wr_way] <= wr_data[g*DATA_W +: DATA_W];
        rd_q <= ram[rd_way];
      end

      assign rd_data[g*DATA_W +: DATA_W] = rd_q;
    end
  endgenerate

endmodule

// File: rtl/wtc_cache.sv
module wtc_cache #(
  parameter int ADDR_W      = 5,
  parameter int BLOCK_BYTES = 2,
  parameter int LINES       = 2,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cpu_rd,
  input  logic                          cpu_wr,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic [DATA_W-1:0]             cpu_rdata,
  output logic                          cpu_ready,
  output logic                          mem_rd_req,
  output logic                          mem_wr_req,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  input  logic [BLOCK_BYTES*DATA_W-1:0] mem_rdata,
  input  logic                          mem_ack,
  output logic [CNT_W-1:0]              hit_count,
  output logic [CNT_W-1:0]              miss_count
);
  import wtc_pkg::*;

  localparam int OFFS_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
  localparam int TAG_W  = ADDR_W - OFFS_W;
  localparam int WAY_W  = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int BLK_W  = BLOCK_BYTES * DATA_W;

  wtc_state_t        state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_wr_q;
  logic [DATA_W-1:0] req_data_q;
  logic [WAY_W-1:0]  fill_way_q;

  logic [TAG_W-1:0]  look_tag;
  logic [OFFS_W-1:0] offs;
  logic              hit, free_any;
  logic [WAY_W-1:0]  hit_way, free_way, oldest_way, victim;
  logic              fill_done;

  logic [WAY_W-1:0]       d_wr_way;
  logic [BLOCK_BYTES-1:0] d_lane_en;
  logic [BLK_W-1:0]       d_wr_data;
  logic [BLK_W-1:0]       d_rd_data;
  logic [BLK_W-1:0]       fill_line;
  logic                   touch_en;
  logic [WAY_W-1:0]       touch_way;

  assign look_tag  = req_addr_q[ADDR_W-1:OFFS_W];
  assign offs      = req_addr_q[OFFS_W-1:0];
  assign victim    = free_any ? free_way : oldest_way;
  assign fill_done = (state_q == ST_FILL) && mem_ack;

  wtc_tags #(.LINES(LINES), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .look_tag  (look_tag),
    .alloc_en  (fill_done),
    .alloc_way (fill_way_q),
    .alloc_tag (look_tag),
    .hit       (hit),
    .hit_way   (hit_way),
    .free_any  (free_any),
    .free_way  (free_way)
  );

  assign touch_en  = ((state_q == ST_LOOK) && hit) || fill_done;
  assign touch_way = (state_q == ST_LOOK) ? hit_way : fill_way_q;

  wtc_lru #(.LINES(LINES), .WAY_W(WAY_W)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch_en   (touch_en),
    .touch_way  (touch_way),
    .oldest_way (oldest_way)
  );

  // Fill line with the pending store byte merged in
  always_comb begin
    fill_line = mem_rdata;
    if (req_wr_q)
      fill_line[offs*DATA_W +: DATA_W] = req_data_q;
  end

  always_comb begin
    d_wr_way  = hit_way;
    d_lane_en = '0;
    d_wr_data = {BLOCK_BYTES{req_data_q}};
    if (fill_done) begin
      d_wr_way  = fill_way_q;
      d_lane_en = '1;
      d_wr_data = fill_line;
    end else if ((state_q == ST_LOOK) && hit && req_wr_q) begin
      d_lane_en = BLOCK_BYTES'(1) << offs;
    end
  end

  wtc_data #(.LINES(LINES), .BLOCK_BYTES(BLOCK_BYTES), .DATA_W(DATA_W),
             .WAY_W(WAY_W)) u_data (
    .clk        (clk),
    .wr_way     (d_wr_way),
    .wr_lane_en (d_lane_en),
    .wr_data    (d_wr_data),
    .rd_way     (hit_way),
    .rd_data    (d_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      req_addr_q <= '0;
      req_wr_q   <= 1'b0;
      req_data_q <= '0;
      fill_way_q <= '0;
      cpu_rdata  <= '0;
      cpu_ready  <= 1'b0;
      mem_rd_req <= 1'b0;
      mem_wr_req <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_rd || cpu_wr) begin
            req_addr_q <= cpu_addr;
            req_wr_q   <= cpu_wr;
            req_data_q <= cpu_wdata;
            state_q    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            hit_count <= hit_count + 1'b1;
            if (req_wr_q) begin
              mem_wr_req <= 1'b1;
              mem_addr   <= req_addr_q;
              mem_wdata  <= req_data_q;
              state_q    <= ST_STORE;
            end else begin
              state_q <= ST_RESP;
            end
          end else begin
            miss_count <= miss_count + 1'b1;
            fill_way_q <= victim;
            mem_rd_req <= 1'b1;
            mem_addr   <= {look_tag, {OFFS_W{1'b0}}};
            state_q    <= ST_FILL;
          end
        end
        ST_RESP: begin
          cpu_rdata <= d_rd_data[offs*DATA_W +: DATA_W];
          cpu_ready <= 1'b1;
          state_q   <= ST_IDLE;
        end
        ST_FILL: begin
          if (mem_ack) begin
            mem_rd_req <= 1'b0;
            if (req_wr_q) begin
              mem_wr_req <= 1'b1;
              mem_addr   <= req_addr_q;
              mem_wdata  <= req_data_q;
              state_q    <= ST_STORE;
            end else begin
              cpu_rdata <= mem_rdata[offs*DATA_W +: DATA_W];
              cpu_ready <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end
        end
        ST_STORE: begin
          if (mem_ack) begin
            mem_wr_req <= 1'b0;
            cpu_ready  <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: ready lasts exactly one cycle
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R10: no completion while memory still owes an answer
  a_r10_ready_idle_mem: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> (!mem_rd_req && !mem_wr_req));

  // R12: never a read and a write together
  a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && mem_wr_req));

  // R12: a read request holds with a stable address until acknowledged
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_ack) |=> (mem_rd_req && $stable(mem_addr)));

  // R12: a write request holds address and data until acknowledged
  a_r12_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && !mem_ack) |=> (mem_wr_req && $stable(mem_addr) && $stable(mem_wdata)));

  // R4: block reads are block aligned
  a_r4_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (mem_addr[OFFS_W-1:0] == '0));

  // R9: hit and miss never both advance in one cycle
  a_r9_one_count: assert property (@(posedge clk) disable iff (rst)
    !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));

  // R9: a counter moves by exactly one
  a_r9_hit_step: assert property (@(posedge clk) disable iff (rst)
    (hit_count != $past(hit_count)) |-> (hit_count == $past(hit_count) + 1'b1));

endmodule

// File: tb/wtc_cache_test.sv
module wtc_cache_test;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [4:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_ready;
  logic        mem_rd_req, mem_wr_req;
  logic [4:0]  mem_addr;
  logic [7:0]  mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ack;
  logic [15:0] hit_count, miss_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  wtc_cache uut (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .hit_count(hit_count), .miss_count(miss_count)
  );

  // memory model with transaction log
  logic [7:0] mem_img [32];
  int cnt, cyc, rd_cnt, wr_cnt, last_rd_addr, last_wr_addr, last_wr_data;
  int rd_stamp, wr_stamp;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      mem_ack <= 1'b0; cnt <= 0; rd_cnt <= 0; wr_cnt <= 0;
      mem_rdata <= '0; rd_stamp <= 0; wr_stamp <= 0;
      last_rd_addr <= -1; last_wr_addr <= -1; last_wr_data <= -1;
      for (int i = 0; i < 32; i++) mem_img[i] <= 8'((i * 13) + 5);
    end else if (mem_ack) begin
      mem_ack <= 1'b0; cnt <= 0;
    end else if (mem_rd_req || mem_wr_req) begin
      if (cnt == LAT) begin
        mem_ack <= 1'b1;
        if (mem_rd_req) begin
          mem_rdata <= {mem_img[{mem_addr[4:1], 1'b1}], mem_img[{mem_addr[4:1], 1'b0}]};
          rd_cnt <= rd_cnt + 1; last_rd_addr <= int'(mem_addr); rd_stamp <= cyc;
        end else begin
          mem_img[mem_addr] <= mem_wdata;
          wr_cnt <= wr_cnt + 1; last_wr_addr <= int'(mem_addr);
          last_wr_data <= int'(mem_wdata); wr_stamp <= cyc;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference cache state
  bit       m_valid [2];
  bit [3:0] m_tag   [2];
  bit       m_lru;

  task automatic access(input bit wr, input logic [4:0] a, input logic [7:0] d,
                        input bit inject);
    bit hit = 0; int way = 0; int n = 0;
    int exp_rd, h0, m0, r0, w0, both;
    both = m_valid[0] && m_valid[1];
    for (int i = 0; i < 2; i++)
      if (m_valid[i] && m_tag[i] == a[4:1]) begin hit = 1; way = i; end
    exp_rd = int'(mem_img[a]);
    @(negedge clk);
    h0 = hit_count; m0 = miss_count; r0 = rd_cnt; w0 = wr_cnt;
    cpu_rd = !wr; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    @(posedge clk);
    do begin
      @(negedge clk);
      n++;
      cpu_rd = 0; cpu_wr = 0;
      if (inject && n == 2) begin
        cpu_wr = 1; cpu_addr = a ^ 5'h10; cpu_wdata = 8'hEE;
      end
    end while (!cpu_ready && n < 200);
    chk(both ? "R8 hit/miss" : "R2 hit/miss", int'(hit_count - h0), hit ? 1 : 0);
    chk("R9 count", int'(hit_count - h0) + int'(miss_count - m0), 1);
    chk(hit ? "R3 no read" : "R4 one read", rd_cnt - r0, hit ? 0 : 1);
    chk(wr ? "R5 one write" : (both && !hit ? "R7 evict no write" : "R11 no write"),
        wr_cnt - w0, wr ? 1 : 0);
    chk("R10 no pending req", int'(mem_rd_req) + int'(mem_wr_req), 0);
    if (!wr) chk(hit ? "R3 data" : "R4 data", int'(cpu_rdata), exp_rd);
    if (!wr && hit) chk("R3 latency", n, 3);
    if (!hit) chk("R4 aligned addr", last_rd_addr, int'({a[4:1], 1'b0}));
    if (wr) begin
      chk("R5 addr", last_wr_addr, int'(a));
      chk("R5 data", last_wr_data, int'(d));
    end
    if (wr && !hit) chk("R6 fill first", int'(rd_stamp < wr_stamp), 1);
    @(negedge clk);
    chk("R10 pulse", int'(cpu_ready), 0);
    chk("R12 dropped", int'(mem_rd_req) + int'(mem_wr_req), 0);
    if (hit) m_lru = (way == 0);
    else begin
      way = !m_valid[0] ? 0 : (!m_valid[1] ? 1 : int'(m_lru));
      m_valid[way] = 1; m_tag[way] = a[4:1]; m_lru = (way == 0);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    m_valid[0] = 0; m_valid[1] = 0; m_lru = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R1 ready", int'(cpu_ready), 0);
    chk("R1 reqs", int'(mem_rd_req) + int'(mem_wr_req), 0);
    chk("R1 hits", int'(hit_count), 0);
    chk("R1 misses", int'(miss_count), 0);
    access(0, 5'd1, 8'd0, 0);   // miss, way0
    access(0, 5'd0, 8'd0, 0);   // same block hit
    access(0, 5'd7, 8'd0, 0);   // miss, way1
    access(0, 5'd1, 8'd0, 0);   // hit way0
    access(0, 5'd10, 8'd0, 0);  // evicts way1
    access(0, 5'd6, 8'd0, 0);   // miss, evicts way0
    access(1, 5'd10, 8'hA5, 0); // store hit
    access(0, 5'd10, 8'd0, 0);
    access(1, 5'd21, 8'h3C, 0); // store miss
    access(0, 5'd21, 8'd0, 0);
    access(0, 5'd20, 8'd0, 0);
    access(0, 5'd3, 8'd0, 1);   // busy strobe ignored
    access(0, 5'd19, 8'd0, 0);  // untouched by the ignored strobe
    for (int i = 0; i < 32; i++) access(1, 5'(i), 8'((i * 7) ^ 8'h5A), 0);
    for (int i = 0; i < 32; i++) access(0, 5'(31 - i), 8'd0, 0);
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        access(lf[7], {lf[3], lf[11:8]} & 5'h17, lf[15:8], 0);
      end
    end
    done = 1;
    finish_run();
  end

endmodule